// File: doc/BRIEF.md
# Transmit Entry Buffer with Burst-Gap Check

This block is the first stage on the transmit side of a serial streaming link whose data is later striped over lanes. User logic presents 64-bit words on a valid/ready stream, with a start marker on the first word of a burst and an end marker on the last. Each word is stored with its markers in a 32-entry synchronous FIFO. A downstream framer reads the FIFO through a show-ahead pop port.

The ready output is an early warning, not a full flag. It drops when the fill level reaches a programmable threshold, so user logic that reacts a few cycles late still finds room. A word presented while all 32 entries are occupied is dropped, and this sets a sticky overflow flag. The block also watches the idle cycles between bursts. A burst that starts before the configured number of idle cycles has passed sets a sticky gap flag. When valid stays high with no idle cycles, words pass through with nothing inserted.

Top module: `txq_gap_fifo`

## Requirements
- R1: After synchronous active-high reset, `out_avail` is 0, `in_ready` is 1, both error flags are 0, and the idle-gap rule counts as already met, so a start marker in the first cycle after reset raises no gap error.
- R2: Stored words leave in arrival order with their data, start and end markers intact. `out_avail` is 1 whenever at least one word is held, and `out_data`/`out_sob`/`out_eob` show the oldest word before it is popped.
- R3: `in_ready` is 1 exactly when the number of stored words is below the effective threshold. It returns to 1 as soon as the level falls below the threshold; there is no hysteresis.
- R4: The effective threshold is `cfg_thresh` limited to the range 8 to 18. A value below 8 acts as 8 and a value above 18 acts as 18. The usual setting is 15.
- R5: A word presented with `in_valid` high while 32 words are stored is dropped, even if a pop happens in the same cycle, and `err_overflow` is set. The stored words are not changed.
- R6: With `cfg_gap_one` = 0 (the default two-cycle rule), a word with valid and start marker high sets `err_gap` unless at least two cycles with `in_valid` low have passed since the last valid word carrying an end marker.
- R7: With `cfg_gap_one` = 1, a single idle cycle after an end marker is enough. A start marker in the cycle right after an end marker still sets `err_gap`.
- R8: Both error flags hold until a cycle with `err_clear` high clears them. An error event in the same cycle as the clear leaves its flag set.
- R9: `out_pop` while the FIFO is empty has no effect: the FIFO stays empty and a following push is read back correctly.
- R10: With `in_valid` held high and one pop every cycle, every word is stored and delivered in order with no loss and no inserted gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gap_one | input | 1 | 1: one idle cycle required between bursts; 0: two |
| cfg_thresh | input | 5 | Partial-full threshold, limited to 8..18 |
| in_valid | input | 1 | Word presented |
| in_sob | input | 1 | First word of a burst |
| in_eob | input | 1 | Last word of a burst |
| in_data | input | 64 | Word payload |
| in_ready | output | 1 | Level below threshold |
| out_pop | input | 1 | Framer takes the oldest word |
| out_avail | output | 1 | At least one word stored |
| out_sob | output | 1 | Start marker of the oldest word |
| out_eob | output | 1 | End marker of the oldest word |
| out_data | output | 64 | Payload of the oldest word |
| err_clear | input | 1 | One-cycle clear of both error flags |
| err_gap | output | 1 | Sticky burst-gap violation |
| err_overflow | output | 1 | Sticky overflow |

## Verification
A wrong fill level shows up at once in `in_ready`, which the bench compares with its own count every cycle, and later as missing or repeated words at the pop port. A wrong read or write pointer shows up on the next popped word. A gap counter that starts from the wrong value, or that also counts valid cycles, shows up as a wrong `err_gap` one cycle after the start marker that follows an end marker. Tests with zero, one and two idle cycles in both gap modes catch it within a few cycles.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int unsigned TXQ_DATA_W = 64;

    typedef struct packed {
        logic                  sob;
        logic                  eob;
        logic [TXQ_DATA_W-1:0] data;
    } txq_word_t;

    typedef enum logic {
        GAP_TWO = 1'b0,
        GAP_ONE = 1'b1
    } gap_mode_e;

    function automatic int unsigned clamp_thr(int unsigned raw, int unsigned lo, int unsigned hi);
        if (raw < lo) return lo;
        if (raw > hi) return hi;
        return raw;
    endfunction

endpackage

// File: rtl/txq_storage.sv
module txq_storage
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  txq_word_t     wr_word,
    input  logic          rd_en,
    output txq_word_t     rd_word,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);

    txq_word_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            case ({wr_en, rd_en})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign rd_word = mem[rd_ptr];
    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);

endmodule

// File: rtl/txq_gap_check.sv
module txq_gap_check
    import txq_pkg::*;
#(
    parameter int unsigned GAP_LONG  = 2,
    parameter int unsigned GAP_SHORT = 1,
    localparam int unsigned IW = $clog2(GAP_LONG + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  gap_mode_e mode,
    input  logic      beat_valid,
    input  logic      beat_sob,
    input  logic      beat_eob,
    output logic      violation
);

    logic [IW-1:0] idle_q;
    logic [IW-1:0] need;

    assign need      = (mode == GAP_ONE) ? IW'(GAP_SHORT) : IW'(GAP_LONG);
    assign violation = beat_valid && beat_sob && (idle_q < need);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= IW'(GAP_LONG);
        end else if (beat_valid) begin
            if (beat_eob) idle_q <= '0;
        end else if (idle_q != IW'(GAP_LONG)) begin
            idle_q <= idle_q + 1'b1;
        end
    end

endmodule

// File: rtl/txq_sticky_flags.sv
module txq_sticky_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [N-1:0] hit,
    output logic [N-1:0] flag
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flag[i] <= 1'b0;
            else     flag[i] <= hit[i] | (flag[i] & ~clear);
        end
    end

endmodule

// File: rtl/txq_gap_fifo.sv
module txq_gap_fifo
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH     = 32,
    parameter int unsigned TH_W      = 5,
    parameter int unsigned TH_MIN    = 8,
    parameter int unsigned TH_MAX    = 18,
    parameter int unsigned GAP_LONG  = 2,
    parameter int unsigned GAP_SHORT = 1,
    localparam int unsigned DW = TXQ_DATA_W,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_gap_one,
    input  logic [TH_W-1:0] cfg_thresh,
    input  logic          in_valid,
    input  logic          in_sob,
    input  logic          in_eob,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          out_pop,
    output logic          out_avail,
    output logic          out_sob,
    output logic          out_eob,
    output logic [DW-1:0] out_data,
    input  logic          err_clear,
    output logic          err_gap,
    output logic          err_overflow
);

    txq_word_t     wr_word, rd_word;
    logic [CW-1:0] level, eff_thr;
    logic          full, empty, wr_ok, rd_ok, gap_hit, ovf_hit;
    logic [1:0]    flags;

    assign wr_word = '{sob: in_sob, eob: in_eob, data: in_data};
    assign wr_ok   = in_valid && !full;
    assign rd_ok   = out_pop && !empty;
    assign ovf_hit = in_valid && full;

    txq_storage #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_ok),
        .wr_word(wr_word),
        .rd_en  (rd_ok),
        .rd_word(rd_word),
        .level  (level),
        .full   (full),
        .empty  (empty)
    );

    txq_gap_check #(.GAP_LONG(GAP_LONG), .GAP_SHORT(GAP_SHORT)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_gap_one ? GAP_ONE : GAP_TWO),
        .beat_valid(in_valid),
        .beat_sob  (in_sob),
        .beat_eob  (in_eob),
        .violation (gap_hit)
    );

    txq_sticky_flags #(.N(2)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .clear(err_clear),
        .hit  ({ovf_hit, gap_hit}),
        .flag (flags)
    );

    assign eff_thr      = CW'(clamp_thr(32'(cfg_thresh), TH_MIN, TH_MAX));
    assign in_ready     = (level < eff_thr);
    assign out_avail    = !empty;
    assign out_sob      = rd_word.sob;
    assign out_eob      = rd_word.eob;
    assign out_data     = rd_word.data;
    assign err_gap      = flags[0];
    assign err_overflow = flags[1];

endmodule

// File: rtl/txq_gap_fifo_chk.sv
module txq_gap_fifo_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_sob,
    input logic in_eob,
    input logic in_ready,
    input logic out_pop,
    input logic out_avail,
    input logic err_clear,
    input logic err_gap,
    input logic err_overflow
);

    logic eob_last;

    always_ff @(posedge clk) begin
        if (rst) eob_last <= 1'b0;
        else     eob_last <= in_valid && in_eob;
    end

    AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
        !out_avail |-> in_ready); // R3

    AST_PUSH_AVAIL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_avail); // R2

    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (err_gap && !err_clear) |=> err_gap); // R8

    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (err_overflow && !err_clear) |=> err_overflow); // R8

    AST_B2B_BURST: assert property (@(posedge clk) disable iff (rst)
        (eob_last && in_valid && in_sob) |=> err_gap); // R7

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (!out_avail && out_pop && !in_valid) |=> !out_avail); // R9

endmodule

bind txq_gap_fifo txq_gap_fifo_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_sob      (in_sob),
    .in_eob      (in_eob),
    .in_ready    (in_ready),
    .out_pop     (out_pop),
    .out_avail   (out_avail),
    .err_clear   (err_clear),
    .err_gap     (err_gap),
    .err_overflow(err_overflow)
);

// File: tb/txq_gap_fifo_tb.sv
module txq_gap_fifo_tb;

    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_gap_one = 0;
    logic [4:0]  cfg_thresh = 5'd15;
    logic        in_valid = 0, in_sob = 0, in_eob = 0;
    logic [63:0] in_data = '0;
    logic        in_ready, out_pop = 0, out_avail, out_sob, out_eob;
    logic [63:0] out_data;
    logic        err_clear = 0, err_gap, err_overflow;

    always #5 clk = ~clk;

    txq_gap_fifo u_dut (.*);

    int checks = 0, fails = 0;
    string tag = "R1";

    logic [65:0] q[$];
    int  idle = 2;
    bit  m_gap = 0, m_ovf = 0;

    function automatic int thr_eff(int raw);
        return raw < 8 ? 8 : (raw > 18 ? 18 : raw);
    endfunction

    task automatic expect_eq(string t, logic [65:0] act, logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic compare();
        expect_eq({tag, " in_ready"}, 66'(in_ready), 66'(q.size() < thr_eff(int'(cfg_thresh))));
        expect_eq({tag, " out_avail"}, 66'(out_avail), 66'(q.size() > 0));
        if (q.size() > 0) expect_eq({tag, " head word"}, {out_sob, out_eob, out_data}, q[0]);
        expect_eq({tag, " err_gap"}, 66'(err_gap), 66'(m_gap));
        expect_eq({tag, " err_overflow"}, 66'(err_overflow), 66'(m_ovf));
    endtask

    task automatic cyc(input bit v, input bit s, input bit e, input logic [63:0] d,
                       input bit p, input bit c);
        bit full, gev, oev;
        int need;
        @(negedge clk);
        in_valid = v; in_sob = s; in_eob = e; in_data = d; out_pop = p; err_clear = c;
        @(posedge clk);
        need = cfg_gap_one ? 1 : 2;
        full = (q.size() == 32);
        gev  = v && s && (idle < need);
        oev  = v && full;
        if (p && q.size() > 0) void'(q.pop_front());
        if (v && !full) q.push_back({s, e, d});
        if (v) begin
            if (e) idle = 0;
        end else if (idle < 2) idle++;
        m_gap = gev || (m_gap && !c);
        m_ovf = oev || (m_ovf && !c);
        #1;
        compare();
    endtask

    task automatic idle_n(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, 0);
    endtask

    task automatic burst(int len, logic [63:0] base, bit p);
        for (int i = 0; i < len; i++)
            cyc(1, i == 0, i == len - 1, base + 64'(i), p, 0);
    endtask

    task automatic drain();
        while (q.size() > 0) cyc(0, 0, 0, '0, 1, 0);
    endtask

    task automatic do_reset();
        rst = 1;
        in_valid = 0; out_pop = 0; err_clear = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        q.delete(); idle = 2; m_gap = 0; m_ovf = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        tag = "R1";
        compare();
        // R1: start marker right after reset is not a gap error
        burst(3, 64'h100, 0);
        expect_eq("R1 no gap error after reset", 66'(err_gap), 66'(0));

        tag = "R2";
        idle_n(2);
        burst(5, 64'hA000, 0);
        idle_n(2);
        burst(1, 64'hB000, 0);
        drain();
        expect_eq("R2 drained", 66'(out_avail), 66'(0));

        tag = "R3";
        cfg_thresh = 5'd15;
        idle_n(2);
        burst(16, 64'hC000, 0);
        expect_eq("R3 ready low at level 16", 66'(in_ready), 66'(0));
        cyc(0, 0, 0, '0, 1, 0);
        cyc(0, 0, 0, '0, 1, 0);
        expect_eq("R3 ready back below threshold", 66'(in_ready), 66'(1));
        drain();

        tag = "R4";
        cfg_thresh = 5'd3;
        burst(9, 64'hD000, 0);
        expect_eq("R4 low clamp to 8", 66'(in_ready), 66'(0));
        cfg_thresh = 5'd25;
        #1;
        compare();
        idle_n(2);
        burst(9, 64'hD100, 0);
        expect_eq("R4 high clamp to 18", 66'(in_ready), 66'(0));
        drain();
        cfg_thresh = 5'd15;

        tag = "R5";
        idle_n(2);
        burst(32, 64'hE000, 0);
        cyc(1, 0, 0, 64'hDEAD, 1, 0);
        expect_eq("R5 overflow flag", 66'(err_overflow), 66'(1));
        drain();

        tag = "R8";
        cyc(0, 0, 0, '0, 0, 1);
        expect_eq("R8 cleared", 66'(err_overflow), 66'(0));
        burst(32, 64'hF000, 0);
        cyc(1, 1, 1, 64'hBEEF, 0, 1);
        expect_eq("R8 event wins over clear", 66'(err_overflow), 66'(1));
        drain();
        cyc(0, 0, 0, '0, 0, 1);

        tag = "R6";
        cfg_gap_one = 0;
        idle_n(2);
        burst(2, 64'h60, 1);
        burst(2, 64'h61, 1);
        expect_eq("R6 zero idle flagged", 66'(err_gap), 66'(1));
        cyc(0, 0, 0, '0, 1, 1);
        burst(2, 64'h62, 1);
        expect_eq("R6 one idle flagged in two-cycle mode", 66'(err_gap), 66'(1));
        cyc(0, 0, 0, '0, 1, 1);
        idle_n(1);
        burst(2, 64'h63, 1);
        expect_eq("R6 two idle accepted", 66'(err_gap), 66'(0));
        drain();

        tag = "R7";
        cfg_gap_one = 1;
        idle_n(1);
        burst(2, 64'h70, 1);
        idle_n(1);
        burst(2, 64'h71, 1);
        expect_eq("R7 one idle accepted", 66'(err_gap), 66'(0));
        burst(2, 64'h72, 1);
        expect_eq("R7 zero idle flagged", 66'(err_gap), 66'(1));
        cyc(0, 0, 0, '0, 1, 1);
        cfg_gap_one = 0;
        drain();

        tag = "R9";
        idle_n(2);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0, 1, 0);
        expect_eq("R9 still empty", 66'(out_avail), 66'(0));
        burst(1, 64'h9999, 0);
        expect_eq("R9 push after empty pops", {out_sob, out_eob, out_data}, {2'b11, 64'h9999});
        drain();

        tag = "R10";
        idle_n(2);
        cyc(1, 1, 0, 64'h1000, 0, 0);
        for (int i = 1; i < 120; i++) cyc(1, 0, 0, 64'h1000 + 64'(i), 1, 0);
        expect_eq("R10 level steady", 66'(q.size()), 66'(1));
        expect_eq("R10 no overflow", 66'(err_overflow), 66'(0));
        drain();

        tag = "R1";
        do_reset();
        #1;
        compare();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule